// File: doc/BRIEF.md
# Parallel Unrolled LFSR Engine

This block computes, in one combinational evaluation, where a linear-feedback shift register lands after absorbing a whole word of input bits. It takes the current register contents and a data word. It returns the advanced register contents and the word of bits the register emitted on the way. There is no clock and no storage inside. A wrapper that needs a running checksum, scrambler or pattern generator holds the state in its own flop and feeds it back. That wrapper also applies any seed value and any final inversion.

One set of parameters picks the structure. Galois feedback suits checksums. Fibonacci feedback suits pseudorandom generators and scramblers, with a feed-forward variant for self-synchronising descramblers. The parameters also set the register length, the feedback taps, the bit order and the number of bits absorbed per evaluation. The polynomial parameter leaves out its highest term, which the register length implies. The logic comes from unrolling the one-bit recurrence at elaboration, so no XOR matrix is written by hand. To run a generator with no data, tie the data word to zero and set the data width to the number of steps wanted per evaluation.

Top module: `lfsr_unrolled_engine`

## Requirements
- R1: In Galois mode with reversed order, a 32-bit engine with taps 0x04C11DB7, fed bytes in stream order from an all-ones state, ends in a state whose bitwise inverse is the standard CRC-32: 0xE8B7BE43 for "a", 0x352441C2 for "abc", 0xCBF43926 for "123456789", and 0x00000000 for an empty message.
- R2: With natural order, data is absorbed from the most significant bit down. A 16-bit Galois engine with taps 0x1021, started at 0xFFFF and fed "123456789", ends at 0x29B1.
- R3: The engine performs exactly one register step per data bit. A 32-bit-wide data word gives the same state as its four bytes absorbed one after another, lowest byte first, when order is reversed.
- R4: In Fibonacci mode the feedback bit is the input bit XOR the top stage XOR every stage k-1 whose polynomial bit k (k ≥ 1) is set. The feedback bit enters stage 0 and older contents move up one stage. When the data width is smaller than the register length, the upper bits of the new state are the lower bits of the old state.
- R5: In every mode the emitted bit for each input bit is its feedback bit, placed at the same position as that input bit. In Fibonacci mode without feed-forward, the newest stages of the state therefore equal the emitted bits.
- R6: With feed-forward, the raw input bit enters stage 0 in place of the feedback bit. An engine of this kind fed a scrambler's output recovers the scrambler's input once at least register-length bits have passed, whatever its starting state.
- R7: An all-zero state with all-zero data gives an all-zero next state and an all-zero emitted word.
- R8: A 7-bit Fibonacci engine with taps 0x41, stepped one bit at a time with zero data from state 0000001, first returns to 0000001 after exactly 127 steps.
- R9: When the data word is wider than the register, bits absorbed early in the word feed back into the treatment of later bits in the same evaluation, and the result equals the bit-serial recurrence.
- R10: Reversed order applies at all four ports: state in, state out, data in and data out are bit-reversed against the internal register. With this ordering the Galois engine matches the bit-serial recurrence for arbitrary states and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | DATA_W | Data word absorbed in this evaluation |
| stateIn | input | STATE_W | Current register contents |
| dataOut | output | DATA_W | Feedback bits produced, one per input bit |
| stateOut | output | STATE_W | Register contents after DATA_W steps |

## Verification
Within a single evaluation, two actions of the recurrence can act on the same bits: shifting the new input in and tapping the stages for feedback. A bit shifted in early in the word can become a tap for a later bit of the same word. This is provoked with a 7-bit Fibonacci engine taking 16-bit words, and with a 58-bit scrambler whose words shift earlier bits toward its taps. Every emitted bit and state bit is compared against a bit-serial model over random states and data. The checksum engines are judged against published check values, and the descrambler against the data the scrambler received.

// File: rtl/lfsr_eng_pkg.sv
package lfsr_eng_pkg;

  // Structure of the feedback network.
  typedef enum logic {
    LFSR_FIBONACCI = 1'b0,
    LFSR_GALOIS    = 1'b1
  } lfsr_kind_e;

  // Number of trailing bits shared between a word and the register.
  function automatic int tailWidth(input int dataW, input int stateW);
    return (dataW < stateW) ? dataW : stateW;
  endfunction

endpackage

// File: rtl/lfsr_bit_order.sv
module lfsr_bit_order #(
  parameter int WIDTH = 8,
  parameter bit FLIP  = 1'b0
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [WIDTH-1:0] vecOut
);

  generate
    if (FLIP) begin : g_flip
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign vecOut[i] = vecIn[WIDTH-1-i];
      end
    end else begin : g_pass
      assign vecOut = vecIn;
    end
  endgenerate

endmodule

// File: rtl/lfsr_galois_core.sv
module lfsr_galois_core #(
  parameter int STATE_W = 32,
  parameter logic [STATE_W-1:0] TAP_POLY = 32'h04C11DB7,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]  wordIn,
  input  logic [STATE_W-1:0] regIn,
  output logic [DATA_W-1:0]  wordOut,
  output logic [STATE_W-1:0] regOut
);

  logic [STATE_W-1:0] acc;
  logic [DATA_W-1:0]  emitted;
  logic               fbBit;

  // Unrolled recurrence: the first bit consumed is the top bit of the word.
  always_comb begin
    acc     = regIn;
    emitted = '0;
    fbBit   = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fbBit      = acc[STATE_W-1] ^ wordIn[i];
      acc        = {acc[STATE_W-2:0], 1'b0} ^ ({STATE_W{fbBit}} & TAP_POLY);
      emitted[i] = fbBit;
    end
  end

  assign regOut  = acc;
  assign wordOut = emitted;

endmodule

// File: rtl/lfsr_fib_core.sv
module lfsr_fib_core #(
  parameter int STATE_W = 32,
  parameter logic [STATE_W-1:0] TAP_POLY = 32'h04C11DB7,
  parameter bit FEED_FWD = 1'b0,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]  wordIn,
  input  logic [STATE_W-1:0] regIn,
  output logic [DATA_W-1:0]  wordOut,
  output logic [STATE_W-1:0] regOut
);

  // Coefficient k taps stage k-1; the implied top term taps the top stage.
  localparam logic [STATE_W-2:0] TAP_MASK = TAP_POLY[STATE_W-1:1];

  logic [STATE_W-1:0] acc;
  logic [DATA_W-1:0]  emitted;
  logic               fbBit;
  logic               inBit;

  always_comb begin
    acc     = regIn;
    emitted = '0;
    fbBit   = 1'b0;
    inBit   = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fbBit      = wordIn[i] ^ acc[STATE_W-1] ^ (^(acc[STATE_W-2:0] & TAP_MASK));
      inBit      = FEED_FWD ? wordIn[i] : fbBit;
      acc        = {acc[STATE_W-2:0], inBit};
      emitted[i] = fbBit;
    end
  end

  assign regOut  = acc;
  assign wordOut = emitted;

endmodule

// File: rtl/lfsr_unrolled_engine.sv
module lfsr_unrolled_engine
  import lfsr_eng_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter logic [STATE_W-1:0] TAP_POLY = 32'h04C11DB7,
  parameter lfsr_kind_e KIND = LFSR_GALOIS,
  parameter bit FEED_FWD = 1'b0,
  parameter bit FLIP_ORDER = 1'b1,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [STATE_W-1:0] stateIn,
  output logic [DATA_W-1:0]  dataOut,
  output logic [STATE_W-1:0] stateOut
);

  logic [DATA_W-1:0]  wordInt;
  logic [DATA_W-1:0]  wordEmit;
  logic [STATE_W-1:0] regCur;
  logic [STATE_W-1:0] regNext;

  // Bit ordering is pure wiring at the four edges.
  lfsr_bit_order #(.WIDTH(DATA_W),  .FLIP(FLIP_ORDER)) u_ordDataIn
    (.vecIn(dataIn),   .vecOut(wordInt));
  lfsr_bit_order #(.WIDTH(STATE_W), .FLIP(FLIP_ORDER)) u_ordStateIn
    (.vecIn(stateIn),  .vecOut(regCur));
  lfsr_bit_order #(.WIDTH(DATA_W),  .FLIP(FLIP_ORDER)) u_ordDataOut
    (.vecIn(wordEmit), .vecOut(dataOut));
  lfsr_bit_order #(.WIDTH(STATE_W), .FLIP(FLIP_ORDER)) u_ordStateOut
    (.vecIn(regNext),  .vecOut(stateOut));

  generate
    if (KIND == LFSR_GALOIS) begin : g_galois
      lfsr_galois_core #(
        .STATE_W(STATE_W), .TAP_POLY(TAP_POLY), .DATA_W(DATA_W)
      ) u_core (
        .wordIn(wordInt), .regIn(regCur), .wordOut(wordEmit), .regOut(regNext)
      );
    end else begin : g_fib
      lfsr_fib_core #(
        .STATE_W(STATE_W), .TAP_POLY(TAP_POLY), .FEED_FWD(FEED_FWD), .DATA_W(DATA_W)
      ) u_core (
        .wordIn(wordInt), .regIn(regCur), .wordOut(wordEmit), .regOut(regNext)
      );
    end
  endgenerate

endmodule

// File: rtl/lfsr_engine_chk.sv
module lfsr_engine_chk #(
  parameter int STATE_W = 32,
  parameter int DATA_W = 8,
  parameter bit IS_GALOIS = 1'b1,
  parameter bit FEED_FWD = 1'b0,
  parameter bit FLIP_ORDER = 1'b1
) (
  input logic [DATA_W-1:0]  dataIn,
  input logic [STATE_W-1:0] stateIn,
  input logic [DATA_W-1:0]  dataOut,
  input logic [STATE_W-1:0] stateOut
);

  localparam int TAIL_W = lfsr_eng_pkg::tailWidth(DATA_W, STATE_W);

  // Views in register order, independent of the port ordering.
  logic [DATA_W-1:0]  dI, dO;
  logic [STATE_W-1:0] sI, sO;

  generate
    if (FLIP_ORDER) begin : g_rev
      for (genvar i = 0; i < DATA_W; i++) begin : g_d
        assign dI[i] = dataIn[DATA_W-1-i];
        assign dO[i] = dataOut[DATA_W-1-i];
      end
      for (genvar i = 0; i < STATE_W; i++) begin : g_s
        assign sI[i] = stateIn[STATE_W-1-i];
        assign sO[i] = stateOut[STATE_W-1-i];
      end
    end else begin : g_nat
      assign dI = dataIn;
      assign dO = dataOut;
      assign sI = stateIn;
      assign sO = stateOut;
    end
  endgenerate

  always_comb begin
    if (stateIn == '0 && dataIn == '0) begin
      // R7
      zero_fixed_chk: assert (stateOut == '0 && dataOut == '0)
        else $error("R7 zero state did not stay zero");
    end
  end

  generate
    if (!IS_GALOIS && !FEED_FWD) begin : g_fibTail
      always_comb begin
        // R5
        fib_emit_tail_chk: assert (sO[TAIL_W-1:0] == dO[TAIL_W-1:0])
          else $error("R5 newest stages differ from emitted bits");
      end
    end
    if (!IS_GALOIS && FEED_FWD) begin : g_ffTail
      always_comb begin
        // R6
        ff_raw_tail_chk: assert (sO[TAIL_W-1:0] == dI[TAIL_W-1:0])
          else $error("R6 newest stages differ from raw input");
      end
    end
    if (!IS_GALOIS && DATA_W < STATE_W) begin : g_carry
      always_comb begin
        // R4
        shift_carry_chk: assert (sO[STATE_W-1:DATA_W] == sI[STATE_W-1-DATA_W:0])
          else $error("R4 older stages did not move up by the word width");
      end
    end
  endgenerate

endmodule

bind lfsr_unrolled_engine lfsr_engine_chk #(
  .STATE_W(STATE_W),
  .DATA_W(DATA_W),
  .IS_GALOIS(KIND == lfsr_eng_pkg::LFSR_GALOIS),
  .FEED_FWD(FEED_FWD),
  .FLIP_ORDER(FLIP_ORDER)
) u_chk (
  .dataIn(dataIn),
  .stateIn(stateIn),
  .dataOut(dataOut),
  .stateOut(stateOut)
);

// File: tb/lfsr_unrolled_engine_tb.sv
module lfsr_unrolled_engine_tb;
  import lfsr_eng_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Default engine: 32-bit Galois, reversed, byte wide.
  logic [7:0]  d8In = '0;
  logic [31:0] s32In = '0;
  wire  [7:0]  d8Out;
  wire  [31:0] s32Out;
  lfsr_unrolled_engine u_dut (.dataIn(d8In), .stateIn(s32In), .dataOut(d8Out), .stateOut(s32Out));

  logic [31:0] wDIn = '0, wSIn = '0;
  wire  [31:0] wDOut, wSOut;
  lfsr_unrolled_engine #(.DATA_W(32)) u_wide
    (.dataIn(wDIn), .stateIn(wSIn), .dataOut(wDOut), .stateOut(wSOut));

  logic [7:0]  c16D = '0;
  logic [15:0] c16S = '0;
  wire  [7:0]  c16DOut;
  wire  [15:0] c16SOut;
  lfsr_unrolled_engine #(.STATE_W(16), .TAP_POLY(16'h1021), .FLIP_ORDER(1'b0), .DATA_W(8)) u_crc16
    (.dataIn(c16D), .stateIn(c16S), .dataOut(c16DOut), .stateOut(c16SOut));

  logic [15:0] scrD = '0;
  logic [57:0] scrS = '0, dsS = '0;
  wire  [15:0] scrDOut, dsDOut;
  wire  [57:0] scrSOut, dsSOut;
  lfsr_unrolled_engine #(.STATE_W(58), .TAP_POLY(58'h8000000001), .KIND(LFSR_FIBONACCI),
    .FEED_FWD(1'b0), .FLIP_ORDER(1'b1), .DATA_W(16)) u_scr
    (.dataIn(scrD), .stateIn(scrS), .dataOut(scrDOut), .stateOut(scrSOut));
  lfsr_unrolled_engine #(.STATE_W(58), .TAP_POLY(58'h8000000001), .KIND(LFSR_FIBONACCI),
    .FEED_FWD(1'b1), .FLIP_ORDER(1'b1), .DATA_W(16)) u_dscr
    (.dataIn(scrDOut), .stateIn(dsS), .dataOut(dsDOut), .stateOut(dsSOut));

  logic [6:0] prS = '0;
  logic [0:0] prD = '0;
  wire  [6:0] prSOut;
  wire  [0:0] prDOut;
  lfsr_unrolled_engine #(.STATE_W(7), .TAP_POLY(7'h41), .KIND(LFSR_FIBONACCI),
    .FLIP_ORDER(1'b0), .DATA_W(1)) u_prbs
    (.dataIn(prD), .stateIn(prS), .dataOut(prDOut), .stateOut(prSOut));

  logic [15:0] fwD = '0;
  logic [6:0]  fwS = '0;
  wire  [15:0] fwDOut;
  wire  [6:0]  fwSOut;
  lfsr_unrolled_engine #(.STATE_W(7), .TAP_POLY(7'h41), .KIND(LFSR_FIBONACCI),
    .FLIP_ORDER(1'b0), .DATA_W(16)) u_fibWide
    (.dataIn(fwD), .stateIn(fwS), .dataOut(fwDOut), .stateOut(fwSOut));

  typedef struct packed {
    logic [3:0]  len;
    logic [71:0] msg;   // byte 0 in bits 7:0
    logic [31:0] crc;
  } crcVec_t;

  localparam crcVec_t VEC [4] = '{
    '{4'd0, 72'h0,                     32'h00000000},
    '{4'd1, 72'h61,                    32'hE8B7BE43},
    '{4'd3, 72'h636261,                32'h352441C2},
    '{4'd9, 72'h393837363534333231,    32'hCBF43926}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] rev(input logic [63:0] v, input int n);
    logic [63:0] r = '0;
    for (int j = 0; j < n; j++) r[j] = v[n-1-j];
    return r;
  endfunction

  // Bit-serial model of the requirements.
  function automatic void refStep(input bit gal, input bit ff, input bit flip,
                                  input int w, input int d, input logic [63:0] poly,
                                  input logic [63:0] sIn, input logic [63:0] dIn,
                                  output logic [63:0] sOut, output logic [63:0] dOut);
    logic [63:0] s, x, o, mask;
    logic b, fb, taps;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    s = flip ? rev(sIn, w) : sIn;
    x = flip ? rev(dIn, d) : dIn;
    o = '0;
    for (int i = d - 1; i >= 0; i--) begin
      b = x[i];
      if (gal) begin
        fb = s[w-1] ^ b;
        s = ((s << 1) & mask) ^ (fb ? (poly & mask) : 64'd0);
      end else begin
        taps = s[w-1];
        for (int k = 1; k < w; k++) if (poly[k]) taps = taps ^ s[k-1];
        fb = b ^ taps;
        s = ((s << 1) & mask) | {63'd0, (ff ? b : fb)};
      end
      o[i] = fb;
    end
    sOut = flip ? rev(s, w) : s;
    dOut = flip ? rev(o, d) : o;
  endfunction

  task automatic dutByte(input logic [7:0] b);
    logic [31:0] t;
    @(negedge clk);
    d8In = b;
    #1;
    t = s32Out;
    s32In = t;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] es, ed;
    logic [31:0] t32;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: all-zero inputs on several engines
    @(negedge clk);
    d8In = '0; s32In = '0; scrD = '0; scrS = '0; fwD = '0; fwS = '0;
    #1;
    check("R7 galois state", {32'd0, s32Out}, 64'd0);
    check("R7 galois data", {56'd0, d8Out}, 64'd0);
    check("R7 fib state", {6'd0, scrSOut}, 64'd0);
    check("R7 fib data", {57'd0, fwSOut}, 64'd0);

    // R1: table of CRC-32 check values
    for (int v = 0; v < 4; v++) begin
      s32In = 32'hFFFFFFFF;
      for (int i = 0; i < int'(VEC[v].len); i++) dutByte(VEC[v].msg[8*i +: 8]);
      #1;
      check($sformatf("R1 crc32 vector %0d", v), {32'd0, ~s32In}, {32'd0, VEC[v].crc});
    end

    // R2: natural-order CRC-16
    c16S = 16'hFFFF;
    for (int i = 0; i < 9; i++) begin
      logic [15:0] t16;
      @(negedge clk);
      c16D = 8'h31 + 8'(i);
      #1;
      t16 = c16SOut;
      c16S = t16;
    end
    check("R2 crc16 msb-first", {48'd0, c16S}, 64'h29B1);

    // R3: two 32-bit words then one byte
    @(negedge clk);
    wSIn = 32'hFFFFFFFF; wDIn = 32'h34333231;
    #1; t32 = wSOut;
    @(negedge clk);
    wSIn = t32; wDIn = 32'h38373635;
    #1; t32 = wSOut;
    s32In = t32;
    dutByte(8'h39);
    #1;
    check("R3 wide word chain", {32'd0, ~s32In}, 64'hCBF43926);

    // R3 and R10: random compare of wide and byte Galois engines
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      wSIn = $urandom; wDIn = $urandom; s32In = $urandom; d8In = 8'($urandom);
      #1;
      refStep(1'b1, 1'b0, 1'b1, 32, 32, 64'h04C11DB7, {32'd0, wSIn}, {32'd0, wDIn}, es, ed);
      check("R3 wide state", {32'd0, wSOut}, es);
      check("R5 wide emitted", {32'd0, wDOut}, ed);
      refStep(1'b1, 1'b0, 1'b1, 32, 8, 64'h04C11DB7, {32'd0, s32In}, {56'd0, d8In}, es, ed);
      check("R10 reversed galois state", {32'd0, s32Out}, es);
      check("R10 reversed galois data", {56'd0, d8Out}, ed);
    end

    // R4, R5, R6: scrambler against model; descrambler self-syncs
    scrS = {$urandom, $urandom};
    dsS = {$urandom, $urandom};
    for (int n = 0; n < 24; n++) begin
      logic [57:0] ns, nd;
      @(negedge clk);
      scrD = 16'($urandom);
      #1;
      refStep(1'b0, 1'b0, 1'b1, 58, 16, 64'h8000000001, {6'd0, scrS}, {48'd0, scrD}, es, ed);
      check("R4 scrambler state", {6'd0, scrSOut}, es);
      check("R5 scrambler emitted", {48'd0, scrDOut}, ed);
      if (n >= 4) check("R6 descrambled data", {48'd0, dsDOut}, {48'd0, scrD});
      ns = scrSOut; nd = dsSOut;
      scrS = ns; dsS = nd;
    end

    // R8: period of the 7-bit generator
    begin
      int firstHit = 0;
      prS = 7'd1;
      for (int n = 1; n <= 130; n++) begin
        logic [6:0] t7;
        @(negedge clk);
        #1;
        t7 = prSOut;
        if (t7 == 7'd1 && firstHit == 0) firstHit = n;
        prS = t7;
      end
      check("R8 generator period", 64'(firstHit), 64'd127);
    end

    // R9: word wider than the register
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      fwS = 7'($urandom); fwD = 16'($urandom);
      #1;
      refStep(1'b0, 1'b0, 1'b0, 7, 16, 64'h41, {57'd0, fwS}, {48'd0, fwD}, es, ed);
      check("R9 wide-word fib state", {57'd0, fwSOut}, es);
      check("R9 wide-word fib data", {48'd0, fwDOut}, ed);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule